// File: doc/BRIEF.md
# I2C Byte Slave with Pin-Strapped Address

This block lets an external I2C master exchange single bytes with a processor core. It runs entirely on a fast system clock. The bus lines SCL and SDA are treated as plain inputs, and each one passes through a two-flop synchronizer and a glitch filter. The block then detects START and STOP conditions and clock edges. It compares the received address with a 7-bit value whose upper five bits are fixed and whose lowest two bits come from strap pins. The line is only ever pulled low: the output is an open-drain enable, and a pull-up on the board supplies the high level.

On a write, each byte the master sends goes to the core as a one-cycle valid pulse, and the slave acknowledges it. On a read, the slave asks the core for a byte with a one-cycle request and shifts that byte out MSB first. It keeps doing this while the master acknowledges. A repeated START is deliberately not honoured. Once a transfer has begun, any further START makes the slave let go of the line and stay silent until a STOP. Both 100 kbit/s and 400 kbit/s bus timing are supported. Clock stretching, general call and 10-bit addresses are not supported.

Top module: `i2c_strap_slave`

## Requirements
- R1: The slave answers address `{0,0,1,1,1,strap_a2,strap_a1}` (MSB first, followed by the R/W bit, 1 = read). A strap pin tied low counts as 0 and tied high as 1. After a matching address byte the slave pulls SDA low (`sda_oe`=1) for the whole ninth clock.
- R2: After a non-matching address the slave never pulls SDA, and it produces neither `wr_valid` nor `rd_req` until a STOP and a new START.
- R3: In a write transfer, every 8-bit byte that follows the address appears once on `wr_data` with a single-cycle `wr_valid` pulse, in order, MSB received first. The slave acknowledges each such byte in the ninth clock.
- R4: In a read transfer, the slave raises `rd_req` for one cycle and captures `rd_data` in that cycle. It then drives the byte MSB first, and the level on SDA changes only while SCL is low.
- R5: A master ACK (SDA low in the ninth clock of a read byte) triggers one more `rd_req` and the next byte. A master NACK ends the read: the slave keeps SDA released and issues no `rd_req` until a STOP.
- R6: A START seen while a transfer is open is not treated as a new transfer. The slave releases SDA, ignores the bytes that follow (no ACK, no `wr_valid`) and waits for a STOP.
- R7: A STOP returns the slave to idle from any state, and the next START is accepted normally.
- R8: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks is ignored. It adds no bit and creates no START or STOP.
- R9: While `rst_n` is low at a clock edge, all outputs go to their inactive state: `sda_oe`, `wr_valid` and `rd_req` are 0.
- R10: Transfers run correctly at both 100 kbit/s and 400 kbit/s SCL timing when the system clock is 200 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a1 | input | 1 | Strap for address bit 0 |
| strap_a2 | input | 1 | Strap for address bit 1 |
| scl_in | input | 1 | Level seen on the SCL line |
| sda_in | input | 1 | Level seen on the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it to the pull-up |
| wr_valid | output | 1 | One-cycle pulse: a written byte is on wr_data |
| wr_data | output | DATA_W | Byte received from the master |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_data | input | DATA_W | Byte to send, sampled in the cycle rd_req is high |

## Verification
Writes are tried with two data bytes of alternating and inverted bit patterns, and reads with two bytes ended first by ACK and then by NACK. Together these show whether byte order, MSB-first shifting and the master-ACK decision are right. An address one bit off the strap value, and a change of the strap pins between transfers, show that both strap bits take part in the match. A write interrupted by a repeated START, followed by a fresh transfer after STOP, shows the difference between ignoring Sr and honouring it. Single-cycle spikes on SCL and on SDA inside a data bit, and one transfer at standard-mode timing, show whether the filter rejects noise without losing real edges.

// File: rtl/i2cs_pkg.sv
// Shared types for the strap-addressed I2C slave.
package i2cs_pkg;

    // Protocol engine states.
    typedef enum logic [2:0] {
        ST_IDLE,       // no transfer open, waiting for START
        ST_ADDR,       // shifting in address + R/W
        ST_ADDR_ACK,   // driving ACK for our address
        ST_WDATA,      // shifting in a write byte
        ST_WACK,       // driving ACK for a write byte
        ST_RDATA,      // shifting out a read byte
        ST_RACK,       // sampling the master's ACK/NACK
        ST_WAIT_STOP   // silent until STOP
    } i2cs_state_e;

    // Fixed upper part of the 7-bit slave address.
    localparam logic [4:0] ADDR_FIXED = 5'b00111;

endpackage

// File: rtl/i2cs_deglitch.sv
// Synchronizer plus glitch filter for one bus line.
// Assumes: raw is asynchronous to clk; the output follows the input only
// after FILT_LEN consecutive samples disagree with the current output.
module i2cs_deglitch #(
    parameter int   FILT_LEN  = 3,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          sync1;
    logic          sync2;
    logic [CW-1:0] run_cnt;

    // Two-flop synchronizer into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= RESET_VAL;
            sync2 <= RESET_VAL;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // Accept a new level only after it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean   <= RESET_VAL;
            run_cnt <= '0;
        end else if (sync2 == clean) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            clean   <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cs_bus_events.sv
// Edge and bus-condition detector on filtered SCL/SDA.
// Assumes: inputs are already synchronous and deglitched; both lines see
// the same filter delay, so their relative order is preserved.
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Clock edges and SDA transitions while SCL stays high.
    always_comb begin
        scl_rise  = scl & ~scl_q;
        scl_fall  = ~scl & scl_q;
        start_det = scl & scl_q & sda_q & ~sda;
        stop_det  = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/i2cs_engine.sv
// Byte-level protocol engine: address match, ACK, write and read shifting.
// Assumes: single-cycle event strobes from i2cs_bus_events; rd_data is
// valid in the cycle rd_req is high; STOP has priority over everything.
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic [DATA_W-2:0] dev_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

    i2cs_state_e       state;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              is_read;
    logic              m_nack;

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rx_sh    <= '0;
            tx_sh    <= '0;
            bit_cnt  <= '0;
            is_read  <= 1'b0;
            m_nack   <= 1'b0;
            sda_oe   <= 1'b0;
            wr_valid <= 1'b0;
            wr_data  <= '0;
            rd_req   <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_req   <= 1'b0;
            if (rd_req) begin
                tx_sh <= rd_data;
            end
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                sda_oe <= 1'b0;
                if (state == ST_IDLE) begin
                    state   <= ST_ADDR;
                    bit_cnt <= '0;
                end else begin
                    state <= ST_WAIT_STOP;
                end
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[DATA_W-2:0], sda_bit};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            if (rx_sh[DATA_W-1:1] == dev_addr) begin
                                state   <= ST_ADDR_ACK;
                                sda_oe  <= 1'b1;
                                is_read <= rx_sh[0];
                                rd_req  <= rx_sh[0];
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                state  <= ST_RDATA;
                                sda_oe <= ~tx_sh[DATA_W-1];
                            end else begin
                                state  <= ST_WDATA;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[DATA_W-2:0], sda_bit};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            state    <= ST_WACK;
                            sda_oe   <= 1'b1;
                            wr_valid <= 1'b1;
                            wr_data  <= rx_sh;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            state   <= ST_WDATA;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                state  <= ST_RACK;
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[DATA_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_nack <= sda_bit;
                            rd_req <= ~sda_bit;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (m_nack) begin
                                state <= ST_WAIT_STOP;
                            end else begin
                                state  <= ST_RDATA;
                                sda_oe <= ~tx_sh[DATA_W-1];
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_strap_slave.sv
// Top of the strap-addressed I2C byte slave.
// Assumes: clk is much faster than SCL (at least ~20x the bit rate plus
// the filter length); strap pins are static while a transfer is open.
module i2c_strap_slave #(
    parameter int FILT_LEN = 3,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_a1,
    input  logic              strap_a2,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req,
    input  logic [DATA_W-1:0] rd_data
);
    import i2cs_pkg::*;

    localparam int N_LINES = 2;
    localparam int ADDR_W  = DATA_W - 1;

    logic [N_LINES-1:0] raw_bus;
    logic [N_LINES-1:0] clean_bus;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    logic [ADDR_W-1:0]  dev_addr;

    // Bit 0 carries SCL, bit 1 carries SDA.
    assign raw_bus  = {sda_in, scl_in};
    // Own address: fixed upper bits, straps in the two low bits.
    assign dev_addr = ADDR_W'({ADDR_FIXED, strap_a2, strap_a1});

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2cs_deglitch #(
            .FILT_LEN (FILT_LEN),
            .RESET_VAL(1'b1)
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_bus[g]),
            .clean(clean_bus[g])
        );
    end

    i2cs_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (clean_bus[0]),
        .sda      (clean_bus[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2cs_engine #(
        .DATA_W(DATA_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_bit  (clean_bus[1]),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req)
    );
endmodule

// File: rtl/i2cs_checker.sv
// Port-level protocol checks for i2c_strap_slave, bound below.
// Assumes: synchronous active-low reset on the same clock.
module i2cs_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_oe,
    input logic wr_valid,
    input logic rd_req
);
    logic past_ok;
    logic rst_prev;

    // Marks cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // After an edge taken in reset, every output must be idle.
    always_ff @(posedge clk) begin
        rst_prev <= rst_n;
        if (rst_prev == 1'b0) begin
            // R9
            reset_idle_chk: assert (!sda_oe && !wr_valid && !rd_req)
                else $error("outputs active right after reset");
        end
    end

    // R4
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (sda_oe != $past(sda_oe))) |-> !scl_in);

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R4
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R3
    wr_rd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, rd_req}));
endmodule

bind i2c_strap_slave i2cs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_in  (scl_in),
    .sda_oe  (sda_oe),
    .wr_valid(wr_valid),
    .rd_req  (rd_req)
);

// File: tb/i2c_strap_slave_bench.sv
// Scoreboard bench: the bus driver queues expected write bytes, a monitor
// pops them as wr_valid pulses appear; read bytes are checked on the bus.
module i2c_strap_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       strap_a1;
    logic       strap_a2;
    logic       scl_drv;
    logic       sda_drv;
    logic       sda_in;
    logic       sda_oe;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic       rd_req;
    logic [7:0] rd_data;

    logic [7:0] exp_wr[$];
    logic [7:0] rd_src[4];
    int         rd_cnt  = 0;
    int         rd_base = 0;
    int         wr_cnt  = 0;
    int         n_chk   = 0;
    int         n_fail  = 0;
    int         hp      = 250;
    int         q       = 125;
    bit         done    = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    // Open-drain wired AND of master and slave.
    assign sda_in  = sda_drv & ~sda_oe;
    assign rd_data = rd_src[(rd_cnt - rd_base - 1) & 3];

    i2c_strap_slave u_i2c_strap_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_a1(strap_a1),
        .strap_a2(strap_a2),
        .scl_in  (scl_drv),
        .sda_in  (sda_in),
        .sda_oe  (sda_oe),
        .wr_valid(wr_valid),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_data (rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare written bytes against the queue, count read requests.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && wr_valid === 1'b1) begin
            wr_cnt++;
            if (exp_wr.size() == 0) begin
                chk(1'b0, "R3", "unexpected write byte", wr_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_wr.pop_front();
                chk(wr_data == e, "R3", "write byte", wr_data, e);
            end
        end
        if (rst_n === 1'b1 && rd_req === 1'b1) rd_cnt++;
    end

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_c(q);
        scl_drv = 1'b1; wait_c(q);
        sda_drv = 1'b0; wait_c(q);
        scl_drv = 1'b0; wait_c(q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_c(q);
        scl_drv = 1'b1; wait_c(q);
        sda_drv = 1'b1; wait_c(hp);
    endtask

    // One master bit; gl adds 1-cycle spikes on SCL and SDA while SCL is high.
    task automatic put_bit(input bit b, input bit gl);
        wait_c(q);
        sda_drv = b;
        wait_c(q);
        scl_drv = 1'b1;
        if (gl) begin
            wait_c(q / 2);
            scl_drv = 1'b0; wait_c(1); scl_drv = 1'b1;
            wait_c(q / 2);
            sda_drv = ~b;   wait_c(1); sda_drv = b;
            wait_c(hp - 2 * (q / 2) - 2);
        end else begin
            wait_c(hp);
        end
        scl_drv = 1'b0;
    endtask

    task automatic get_bit(output bit b);
        wait_c(q);
        sda_drv = 1'b1;
        wait_c(q);
        scl_drv = 1'b1;
        wait_c(q);
        b = sda_in;
        wait_c(q);
        scl_drv = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d, input bit gl, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(d[i], gl && (i == 3));
        get_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input bit ack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~ack, 1'b0);
    endtask

    task automatic set_rd(input logic [7:0] b0, input logic [7:0] b1);
        rd_src[0] = b0; rd_src[1] = b1; rd_src[2] = 8'hEE; rd_src[3] = 8'hEE;
        rd_base   = rd_cnt;
    endtask

    initial begin
        bit         ack;
        logic [7:0] d;
        int         base;
        rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1;
        strap_a2 = 1'b1; strap_a1 = 1'b0;
        set_rd(8'h00, 8'h00);
        wait_c(10);
        // R9: reset state
        chk(sda_oe == 1'b0, "R9", "sda_oe in reset", sda_oe, 0);
        chk(wr_valid == 1'b0 && rd_req == 1'b0, "R9", "strobes in reset",
            {wr_valid, rd_req}, 0);
        rst_n = 1'b1;
        wait_c(20);

        // R1/R3: write two bytes to address 0x1E (straps 1,0)
        bus_start();
        write_byte({7'h1E, 1'b0}, 1'b0, ack);
        chk(ack, "R1", "address ack", ack, 1);
        exp_wr.push_back(8'hA5);
        write_byte(8'hA5, 1'b0, ack);
        chk(ack, "R3", "data ack 1", ack, 1);
        exp_wr.push_back(8'h5A);
        write_byte(8'h5A, 1'b0, ack);
        chk(ack, "R3", "data ack 2", ack, 1);
        bus_stop();
        chk(exp_wr.size() == 0, "R3", "bytes delivered", exp_wr.size(), 0);

        // R2: one address bit off the strap value is ignored
        base = wr_cnt;
        bus_start();
        write_byte({7'h1F, 1'b0}, 1'b0, ack);
        chk(!ack, "R2", "foreign address nack", ack, 0);
        write_byte(8'h33, 1'b0, ack);
        chk(!ack, "R2", "byte after foreign address", ack, 0);
        bus_stop();
        chk(wr_cnt == base, "R2", "no write strobes", wr_cnt - base, 0);

        // R4/R5: read two bytes, ACK then NACK, then clock once more
        set_rd(8'hC3, 8'h96);
        base = rd_cnt;
        bus_start();
        write_byte({7'h1E, 1'b1}, 1'b0, ack);
        chk(ack, "R1", "read address ack", ack, 1);
        read_byte(1'b1, d);
        chk(d == 8'hC3, "R4", "read byte 1", d, 8'hC3);
        read_byte(1'b0, d);
        chk(d == 8'h96, "R4", "read byte 2", d, 8'h96);
        read_byte(1'b0, d);
        chk(d == 8'hFF, "R5", "line released after nack", d, 8'hFF);
        chk(rd_cnt - base == 2, "R5", "read requests", rd_cnt - base, 2);
        bus_stop();

        // R6: repeated START inside a write is not honoured
        base = wr_cnt;
        bus_start();
        write_byte({7'h1E, 1'b0}, 1'b0, ack);
        exp_wr.push_back(8'h11);
        write_byte(8'h11, 1'b0, ack);
        bus_start();
        write_byte({7'h1E, 1'b0}, 1'b0, ack);
        chk(!ack, "R6", "address after Sr", ack, 0);
        write_byte(8'h44, 1'b0, ack);
        chk(!ack, "R6", "byte after Sr", ack, 0);
        chk(wr_cnt - base == 1, "R6", "only pre-Sr byte", wr_cnt - base, 1);
        bus_stop();

        // R7: after STOP a new transfer is accepted
        bus_start();
        write_byte({7'h1E, 1'b0}, 1'b0, ack);
        chk(ack, "R7", "address ack after stop", ack, 1);
        exp_wr.push_back(8'h22);
        write_byte(8'h22, 1'b0, ack);
        chk(ack, "R7", "data ack after stop", ack, 1);
        bus_stop();

        // R1: new strap values move the address
        strap_a2 = 1'b0; strap_a1 = 1'b1;
        wait_c(q);
        bus_start();
        write_byte({7'h1D, 1'b0}, 1'b0, ack);
        chk(ack, "R1", "strap 01 address ack", ack, 1);
        bus_stop();
        bus_start();
        write_byte({7'h1E, 1'b0}, 1'b0, ack);
        chk(!ack, "R1", "old address now nack", ack, 0);
        bus_stop();

        // R8: spikes on SCL and SDA inside data bits are filtered
        base = wr_cnt;
        bus_start();
        write_byte({7'h1D, 1'b0}, 1'b0, ack);
        exp_wr.push_back(8'h0F);
        write_byte(8'h0F, 1'b1, ack);
        chk(ack, "R8", "ack with spikes 1", ack, 1);
        exp_wr.push_back(8'hF0);
        write_byte(8'hF0, 1'b1, ack);
        chk(ack, "R8", "ack with spikes 2", ack, 1);
        bus_stop();
        chk(wr_cnt - base == 2, "R8", "byte count with spikes", wr_cnt - base, 2);

        // R10: standard-mode timing
        hp = 1000; q = 500;
        bus_start();
        write_byte({7'h1D, 1'b0}, 1'b0, ack);
        chk(ack, "R10", "standard-mode address ack", ack, 1);
        exp_wr.push_back(8'h77);
        write_byte(8'h77, 1'b0, ack);
        chk(ack, "R10", "standard-mode data ack", ack, 1);
        bus_stop();
        chk(exp_wr.size() == 0, "R10", "all queued bytes seen", exp_wr.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog, R10: the run must finish in time.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule